// File: doc/BRIEF.md
# Two-Thread Multiported Register File

This block is a register file for a core that runs two hardware threads. Every storage entry holds one 65-bit word for each thread: 64 data bits and an even-parity bit that is computed when the word is written. A thread-select input picks the foreground thread. All read ports and the foreground write ports use that thread's copy. A smaller group of background write ports updates the other thread's copy in the same cycle, and the two groups never collide.

There are 128 general registers and 16 kernel registers. While the kernel-alias input is high, register numbers 16 to 31 reach the kernel bank. While it is low, those numbers reach the ordinary general registers. Reads are combinational from the stored array, and writes take effect at the rising clock edge. By default a read returns the value held before that edge. A parameter selects a forwarding variant, in which a read that matches a foreground write in the same cycle returns the incoming word. In the cycle where the thread select differs from its value on the previous edge, no write of either group is performed.

Top module: `rf2t_regfile`

## Requirements
- R1: After reset every entry of both thread copies reads as zero, with the parity bit (bit 64 of each read word) also zero.
- R2: A foreground write stores its 64 data bits in bits 63:0 and the XOR of those bits in bit 64. The word is readable from any read port from the next cycle on.
- R3: In the default variant (BYPASS=0), a read of an entry written in the same cycle returns the value held before that write.
- R4: Each entry keeps an independent word for thread 0 and thread 1 (thread_sel=0 or 1). Reads return the copy named by thread_sel, and this follows a change of thread_sel in the same cycle.
- R5: Background writes (wr_en_i) go to the copy of the thread that thread_sel does not name. A foreground write and a background write to the same register number in the same cycle both take effect, and background writes never change what the foreground thread reads.
- R6: In any cycle in which thread_sel differs from its value at the previous rising edge, no foreground or background write takes effect, and no forwarding occurs. Writes resume in the following cycle.
- R7: With kern_alias=1, register numbers 16 to 31 access kernel registers 0 to 15, which are separate from general registers 16 to 31. With kern_alias=0, those numbers access the general registers.
- R8: When several write ports of one group target the same entry in one cycle, the highest-numbered port's data is stored.
- R9: In the forwarding variant (BYPASS=1), a read that matches an enabled, unsuppressed foreground write returns that write's word (from the highest-numbered matching port) in the same cycle.
- R10: Register numbers 0 to 15 and 32 to 127, register 0 included, are ordinary storage and are not affected by kern_alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| thread_sel | input | 1 | Foreground thread (0 or 1) |
| kern_alias | input | 1 | Route numbers 16..31 to the kernel bank |
| rd_addr | input | NRD*AW | Read register numbers, port p at [p*AW +: AW] |
| rd_data | output | NRD*(DW+1) | Read words with parity at the top bit, port p at [p*(DW+1) +: DW+1] |
| wr_en_a | input | NWA | Foreground write enables |
| wr_addr_a | input | NWA*AW | Foreground write register numbers |
| wr_data_a | input | NWA*DW | Foreground write data |
| wr_en_i | input | NWI | Background write enables |
| wr_addr_i | input | NWI*AW | Background write register numbers |
| wr_data_i | input | NWI*DW | Background write data |

## Verification
Read results are combinational. A change of read address, thread_sel or kern_alias, and forwarding in the BYPASS=1 variant, shows up in the same cycle, while a write shows up only after one rising edge. The bench drives every input just after a falling edge and samples 1 ns later, which is still inside the same low phase. A same-cycle check therefore sees the pre-edge array, and a write check is made in the low phase after the next rising edge. A second instance with BYPASS=1 receives the same stimulus, so the forwarded and unforwarded results of one cycle are compared against each other.

// File: rtl/rf2t_pkg.sv
package rf2t_pkg;
   typedef enum logic {
      THR_0 = 1'b0,
      THR_1 = 1'b1
   } rf2t_thr_e;

   function automatic rf2t_thr_e rf2t_other(input rf2t_thr_e t);
      return (t == THR_0) ? THR_1 : THR_0;
   endfunction
endpackage

// File: rtl/rf2t_addr_map.sv
module rf2t_addr_map #(
   parameter int NGR   = 128,
   parameter int NKR   = 16,
   parameter int KBASE = 16,
   parameter int AW    = 7,
   parameter int PW    = 8
) (
   input  logic [AW-1:0] log_idx,
   input  logic          alias_en,
   output logic [PW-1:0] phys_idx
);
   logic in_band;

   always_comb begin
      in_band  = (int'(log_idx) >= KBASE) && (int'(log_idx) < KBASE + NKR);
      phys_idx = PW'(log_idx);
      if (alias_en && in_band)
         phys_idx = PW'(NGR + int'(log_idx) - KBASE);
   end
endmodule

// File: rtl/rf2t_switch_guard.sv
module rf2t_switch_guard #(
   parameter int NWA = 8,
   parameter int NWI = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           thread_sel,
   input  logic [NWA-1:0] wa_req,
   input  logic [NWI-1:0] wi_req,
   output logic [NWA-1:0] wa_go,
   output logic [NWI-1:0] wi_go
);
   logic thr_q;
   logic switching;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) thr_q <= 1'b0;
      else        thr_q <= thread_sel;
   end

   assign switching = (thread_sel != thr_q);
   assign wa_go     = switching ? '0 : wa_req;
   assign wi_go     = switching ? '0 : wi_req;
endmodule

// File: rtl/rf2t_store.sv
module rf2t_store
   import rf2t_pkg::*;
#(
   parameter int NENT = 144,
   parameter int EW   = 65,
   parameter int PW   = 8,
   parameter int NWA  = 8,
   parameter int NWI  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  rf2t_thr_e         fg_thr,
   input  logic [NWA-1:0]    wa_go,
   input  logic [NWA*PW-1:0] wa_idx,
   input  logic [NWA*EW-1:0] wa_word,
   input  logic [NWI-1:0]    wi_go,
   input  logic [NWI*PW-1:0] wi_idx,
   input  logic [NWI*EW-1:0] wi_word,
   output logic [EW-1:0]     cell_q [2][NENT]
);
   rf2t_thr_e bg_thr;
   assign bg_thr = rf2t_other(fg_thr);

   // later ports overwrite earlier ones: highest index wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int t = 0; t < 2; t++)
            for (int e = 0; e < NENT; e++)
               cell_q[t][e] <= '0;
      end else begin
         for (int p = 0; p < NWA; p++)
            if (wa_go[p]) cell_q[fg_thr][wa_idx[p*PW +: PW]] <= wa_word[p*EW +: EW];
         for (int q = 0; q < NWI; q++)
            if (wi_go[q]) cell_q[bg_thr][wi_idx[q*PW +: PW]] <= wi_word[q*EW +: EW];
      end
   end
endmodule

// File: rtl/rf2t_regfile.sv
module rf2t_regfile
   import rf2t_pkg::*;
#(
   parameter  int DW     = 64,
   parameter  int NGR    = 128,
   parameter  int NKR    = 16,
   parameter  int KBASE  = 16,
   parameter  int NRD    = 12,
   parameter  int NWA    = 8,
   parameter  int NWI    = 2,
   parameter  bit BYPASS = 1'b0,
   localparam int EW     = DW + 1,
   localparam int NENT   = NGR + NKR,
   localparam int AW     = $clog2(NGR),
   localparam int PW     = $clog2(NENT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              thread_sel,
   input  logic              kern_alias,
   input  logic [NRD*AW-1:0] rd_addr,
   output logic [NRD*EW-1:0] rd_data,
   input  logic [NWA-1:0]    wr_en_a,
   input  logic [NWA*AW-1:0] wr_addr_a,
   input  logic [NWA*DW-1:0] wr_data_a,
   input  logic [NWI-1:0]    wr_en_i,
   input  logic [NWI*AW-1:0] wr_addr_i,
   input  logic [NWI*DW-1:0] wr_data_i
);
   if (NRD < 1 || NWA < 1 || NWI < 1) begin : g_bad_ports
      $error("rf2t_regfile: every port group needs at least one port");
   end
   if (NKR > 0 && KBASE + NKR > NGR) begin : g_bad_alias
      $error("rf2t_regfile: kernel alias band exceeds general register space");
   end
   if (DW < 1) begin : g_bad_width
      $error("rf2t_regfile: data width must be positive");
   end

   rf2t_thr_e         fg_thr;
   logic [NWA-1:0]    wa_go;
   logic [NWI-1:0]    wi_go;
   logic [NWA*PW-1:0] wa_idx;
   logic [NWI*PW-1:0] wi_idx;
   logic [NWA*EW-1:0] wa_word;
   logic [NWI*EW-1:0] wi_word;
   logic [NRD*PW-1:0] rd_idx;
   logic [EW-1:0]     cell_q [2][NENT];
   logic [EW-1:0]     view   [NENT];

   assign fg_thr = rf2t_thr_e'(thread_sel);

   rf2t_switch_guard #(.NWA(NWA), .NWI(NWI)) u_guard (
      .clk(clk), .rst_n(rst_n), .thread_sel(thread_sel),
      .wa_req(wr_en_a), .wi_req(wr_en_i),
      .wa_go(wa_go), .wi_go(wi_go)
   );

   for (genvar p = 0; p < NWA; p++) begin : g_wa
      rf2t_addr_map #(.NGR(NGR), .NKR(NKR), .KBASE(KBASE), .AW(AW), .PW(PW)) u_map (
         .log_idx(wr_addr_a[p*AW +: AW]), .alias_en(kern_alias),
         .phys_idx(wa_idx[p*PW +: PW])
      );
      assign wa_word[p*EW +: EW] = {^wr_data_a[p*DW +: DW], wr_data_a[p*DW +: DW]};
   end

   for (genvar q = 0; q < NWI; q++) begin : g_wi
      rf2t_addr_map #(.NGR(NGR), .NKR(NKR), .KBASE(KBASE), .AW(AW), .PW(PW)) u_map (
         .log_idx(wr_addr_i[q*AW +: AW]), .alias_en(kern_alias),
         .phys_idx(wi_idx[q*PW +: PW])
      );
      assign wi_word[q*EW +: EW] = {^wr_data_i[q*DW +: DW], wr_data_i[q*DW +: DW]};
   end

   rf2t_store #(.NENT(NENT), .EW(EW), .PW(PW), .NWA(NWA), .NWI(NWI)) u_store (
      .clk(clk), .rst_n(rst_n), .fg_thr(fg_thr),
      .wa_go(wa_go), .wa_idx(wa_idx), .wa_word(wa_word),
      .wi_go(wi_go), .wi_idx(wi_idx), .wi_word(wi_word),
      .cell_q(cell_q)
   );

   always_comb begin
      for (int e = 0; e < NENT; e++) view[e] = cell_q[fg_thr][e];
   end

   for (genvar r = 0; r < NRD; r++) begin : g_rd
      rf2t_addr_map #(.NGR(NGR), .NKR(NKR), .KBASE(KBASE), .AW(AW), .PW(PW)) u_map (
         .log_idx(rd_addr[r*AW +: AW]), .alias_en(kern_alias),
         .phys_idx(rd_idx[r*PW +: PW])
      );
      if (BYPASS) begin : g_fwd
         always_comb begin
            rd_data[r*EW +: EW] = view[rd_idx[r*PW +: PW]];
            for (int p = 0; p < NWA; p++)
               if (wa_go[p] && wa_idx[p*PW +: PW] == rd_idx[r*PW +: PW])
                  rd_data[r*EW +: EW] = wa_word[p*EW +: EW];
         end
      end else begin : g_plain
         assign rd_data[r*EW +: EW] = view[rd_idx[r*PW +: PW]];
      end
   end
endmodule

// File: rtl/rf2t_chk.sv
module rf2t_chk #(
   parameter int AW  = 7,
   parameter int DW  = 64,
   parameter int NRD = 12,
   parameter int NWA = 8,
   parameter int NWI = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              thread_sel,
   input logic              kern_alias,
   input logic [NRD*AW-1:0] rd_addr,
   input logic [NRD*(DW+1)-1:0] rd_data,
   input logic [NWA-1:0]    wr_en_a,
   input logic [NWA*AW-1:0] wr_addr_a,
   input logic [NWA*DW-1:0] wr_data_a,
   input logic [NWA-1:0]    wa_go,
   input logic [NWI-1:0]    wi_go
);
   localparam int EW = DW + 1;

   // R2: every word that leaves a read port carries consistent parity
   always @(posedge clk) begin
      if (rst_n) begin
         for (int p = 0; p < NRD; p++)
            a_r2_parity: assert (rd_data[p*EW + DW] == ^rd_data[p*EW +: DW])
               else $error("parity mismatch on read port %0d", p);
      end
   end

   // R2: a lone port-0 write is seen by read port 0 one cycle later
   a_r2_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_a == NWA'(1) && thread_sel == $past(thread_sel)
         && wr_addr_a[AW-1:0] == rd_addr[AW-1:0])
      ##1 ($stable(rd_addr) && $stable(thread_sel) && $stable(kern_alias) && wr_en_a == '0)
      |-> rd_data[DW-1:0] == $past(wr_data_a[DW-1:0]));

   // R5: background writes never disturb what the foreground thread reads
   a_r5_background_hidden: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_a == '0)
      ##1 ($stable(rd_addr) && $stable(thread_sel) && $stable(kern_alias) && wr_en_a == '0)
      |-> $stable(rd_data));

   // R6: no write in a thread-change cycle
   a_r6_no_write_on_switch: assert property (@(posedge clk) disable iff (!rst_n)
      (thread_sel != $past(thread_sel)) |-> (wa_go == '0 && wi_go == '0));

   // R6: the block is only one cycle long
   a_r6_resume_after_switch: assert property (@(posedge clk) disable iff (!rst_n)
      (thread_sel == $past(thread_sel)) |-> (wa_go == wr_en_a));
endmodule

bind rf2t_regfile rf2t_chk #(.AW(AW), .DW(DW), .NRD(NRD), .NWA(NWA), .NWI(NWI)) u_chk (
   .clk(clk), .rst_n(rst_n), .thread_sel(thread_sel), .kern_alias(kern_alias),
   .rd_addr(rd_addr), .rd_data(rd_data), .wr_en_a(wr_en_a),
   .wr_addr_a(wr_addr_a), .wr_data_a(wr_data_a), .wa_go(wa_go), .wi_go(wi_go)
);

// File: tb/rf2t_regfile_tb.sv
`timescale 1ns/1ps
module rf2t_regfile_tb;
   localparam int DW = 64, NRD = 12, NWA = 8, NWI = 2, AW = 7, EW = DW + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic thread_sel = 1'b0, kern_alias = 1'b0;
   logic [NRD*AW-1:0] rd_addr = '0;
   logic [NRD*EW-1:0] rd_data, rd_data_b;
   logic [NWA-1:0]    wr_en_a = '0;
   logic [NWA*AW-1:0] wr_addr_a = '0;
   logic [NWA*DW-1:0] wr_data_a = '0;
   logic [NWI-1:0]    wr_en_i = '0;
   logic [NWI*AW-1:0] wr_addr_i = '0;
   logic [NWI*DW-1:0] wr_data_i = '0;
   int checks = 0, failures = 0;

   always #10 clk = ~clk;

   rf2t_regfile u_dut (
      .clk(clk), .rst_n(rst_n), .thread_sel(thread_sel), .kern_alias(kern_alias),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .wr_en_a(wr_en_a), .wr_addr_a(wr_addr_a), .wr_data_a(wr_data_a),
      .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i));

   rf2t_regfile #(.BYPASS(1'b1)) u_dut_byp (
      .clk(clk), .rst_n(rst_n), .thread_sel(thread_sel), .kern_alias(kern_alias),
      .rd_addr(rd_addr), .rd_data(rd_data_b),
      .wr_en_a(wr_en_a), .wr_addr_a(wr_addr_a), .wr_data_a(wr_data_a),
      .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i));

   function automatic logic [EW-1:0] w(input logic [DW-1:0] d);
      return {^d, d};
   endfunction

   task automatic idle();
      wr_en_a = '0; wr_en_i = '0;
   endtask
   task automatic put_a(input int p, input int a, input logic [DW-1:0] d);
      wr_en_a[p] = 1'b1; wr_addr_a[p*AW +: AW] = AW'(a); wr_data_a[p*DW +: DW] = d;
   endtask
   task automatic put_i(input int p, input int a, input logic [DW-1:0] d);
      wr_en_i[p] = 1'b1; wr_addr_i[p*AW +: AW] = AW'(a); wr_data_i[p*DW +: DW] = d;
   endtask
   task automatic ra(input int p, input int a);
      rd_addr[p*AW +: AW] = AW'(a);
   endtask
   task automatic chk(input string req, input int p, input bit byp, input logic [EW-1:0] exp);
      logic [EW-1:0] got;
      got = byp ? rd_data_b[p*EW +: EW] : rd_data[p*EW +: EW];
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s port %0d bypass=%0d: actual %h expected %h", req, p, byp, got, exp);
      end
   endtask
   task automatic nxt();
      @(negedge clk); #1;
   endtask

   localparam logic [DW-1:0] A = 64'h0123_4567_89AB_CDEF, B = 64'h0000_0000_0000_0001;
   localparam logic [DW-1:0] C = 64'hC0C0_0000_1111_2222, D = 64'hD00D_0000_3333_0001;

   task automatic t_reset();
      for (int p = 0; p < NRD; p++) ra(p, p * 10);
      #1;
      chk("R1", 0, 0, '0); chk("R1", 5, 0, '0); chk("R1", 11, 0, '0); chk("R1", 11, 1, '0);
   endtask

   task automatic t_write_read();
      nxt(); idle(); put_a(0, 5, A); put_a(5, 6, B);
      nxt(); idle(); ra(3, 5); ra(4, 6); #1;
      chk("R2", 3, 0, w(A)); chk("R2", 4, 0, w(B));
   endtask

   task automatic t_order();
      nxt(); idle(); put_a(1, 5, C); ra(1, 5); #1;
      chk("R3", 1, 0, w(A)); chk("R9", 1, 1, w(C));
      nxt(); idle(); #1;
      chk("R3", 1, 0, w(C));
   endtask

   task automatic t_priority();
      nxt(); idle(); put_a(2, 9, 64'h22); put_a(7, 9, 64'h77); put_a(4, 9, 64'h44);
      put_i(0, 9, 64'hA0); put_i(1, 9, 64'hA1); ra(0, 9); #1;
      chk("R9", 0, 1, w(64'h77)); chk("R3", 0, 0, '0);
      nxt(); idle(); #1;
      chk("R8", 0, 0, w(64'h77));
   endtask

   task automatic t_threads();
      nxt(); idle(); put_a(0, 40, C); put_i(0, 40, D);
      nxt(); idle(); ra(2, 40); #1;
      chk("R5", 2, 0, w(C));
      nxt(); idle(); thread_sel = 1'b1; put_a(0, 41, A); put_i(1, 41, B); ra(4, 41); #1;
      chk("R4", 2, 0, w(D)); chk("R6", 4, 1, '0);
      nxt(); idle(); ra(3, 9); #1;
      chk("R6", 4, 0, '0); chk("R8", 3, 0, w(64'hA1));
      nxt(); idle(); thread_sel = 1'b0; #1;
      chk("R4", 2, 0, w(C)); chk("R6", 4, 0, '0); chk("R4", 3, 0, w(64'h77));
      nxt(); idle(); put_a(0, 42, D); ra(5, 42);
      nxt(); idle(); #1;
      chk("R6", 5, 0, w(D));
   endtask

   task automatic t_alias();
      nxt(); idle(); kern_alias = 1'b1;
      put_a(0, 20, 64'hCAFE); put_a(1, 15, 64'h15); put_a(2, 32, 64'h32);
      put_a(3, 0, 64'hF00D); put_a(4, 31, 64'h31);
      nxt(); idle(); kern_alias = 1'b0; ra(0, 20); ra(1, 15); ra(2, 32); ra(3, 0); ra(4, 31);
      put_a(0, 20, 64'hBEEF); #1;
      chk("R7", 0, 0, '0); chk("R10", 1, 0, w(64'h15)); chk("R10", 2, 0, w(64'h32));
      chk("R10", 3, 0, w(64'hF00D)); chk("R7", 4, 0, '0);
      nxt(); idle(); #1;
      chk("R7", 0, 0, w(64'hBEEF));
      kern_alias = 1'b1; #1;
      chk("R7", 0, 0, w(64'hCAFE)); chk("R7", 4, 0, w(64'h31));
      chk("R10", 1, 0, w(64'h15)); chk("R10", 3, 0, w(64'hF00D));
      thread_sel = 1'b1; #1;
      chk("R4", 0, 0, '0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_write_read();
      t_order();
      t_priority();
      t_threads();
      t_alias();
      nxt();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule